// File: doc/BRIEF.md
# FSK/DTMF Channel-Seizure Discriminator

This block sits behind a caller-ID demodulator. It is fed one decided line bit per baud interval, sampled at 1200 baud and marked by a one-cycle strobe, plus a flag that is high while a tone receiver reports DTMF activity. From the bit stream it decides whether the call carries an FSK message. The FSK case is recognised by an alternating seizure preamble; when that preamble is absent the signal is treated as DTMF. It drives a mode flag that is high for FSK and low for DTMF.

After the preamble, a run of continuous mark bits must follow. Only once that run is complete does the block open its data path. It then forwards the character frames bit for bit on a serial data output and holds an active-low data-valid. Each frame is a 0 start bit, eight data bits LSB first and a 1 stop bit. Neither the preamble nor the mark bits ever reach the data output.

Once no start bit has arrived for a programmable idle time, the block closes the data path and returns to searching. The default idle time is about 100 ms at a 3.58 MHz clock. A power-down input forces both the data and data-valid outputs high and sends the block back to searching.

The controller has four states:
- HUNT: searching, mode low.
- SEIZE: preamble declared, mode high.
- MARK: counting the mark run.
- DATA: forwarding frames, data-valid low.

It has six transitions:
- HUNT→SEIZE on a long enough alternating run.
- SEIZE→MARK on two successive 1 bits.
- SEIZE→HUNT on two successive 0 bits.
- MARK→DATA when the mark run reaches its minimum.
- MARK→HUNT on a 0 bit in the mark run.
- DATA→HUNT on idle timeout.

Power-down forces any state to HUNT.

Top module: `fsd_seizure_disc`

## Requirements
- R1: Out of reset, fsk_mode is 0, dout is 1 and dv_n is 1.
- R2: When SEIZE_MIN strobed bits in a row each differ from the one before (either starting polarity), fsk_mode goes to 1 in the cycle after the strobe of the last of them. dv_n stays 1.
- R3: Two equal successive bits before the threshold restart the alternation count. The restarted count includes the second of the two bits, and a full SEIZE_MIN alternating bits are again needed.
- R4: After seizure, two successive 1 bits start the mark run, which counts the last preamble 1. dv_n goes to 0 after the strobe that completes MARK_MIN consecutive 1 bits. A 0 bit before that returns to HUNT with fsk_mode 0.
- R5: While dv_n is 1, dout is 1, so no preamble or mark bit is forwarded.
- R6: In DATA, dout takes the value of bit_in at each strobe, starting with the strobe after dv_n fell. Frames are therefore forwarded bit for bit (0 start, 8 data bits LSB first, 1 stop).
- R7: In DATA, a 0 bit seen outside a frame is a start bit and begins a 10-bit frame. After IDLE_CYC clock cycles without a start bit (counted from entry to DATA or from the last start bit), the block returns to HUNT with fsk_mode 0, dv_n 1 and dout 1.
- R8: While dtmf_act is 1 in HUNT, no seizure is declared and the alternation count is cleared. After it drops, a full SEIZE_MIN alternating bits are needed.
- R9: While pwr_dn is 1, dout and dv_n are 1 at once. From the next cycle fsk_mode is 0 and the block is in HUNT.
- R10: In SEIZE, two successive 0 bits return the block to HUNT with fsk_mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe: bit_in holds a new line bit |
| bit_in | input | 1 | Demodulated line bit (1 mark, 0 space) |
| dtmf_act | input | 1 | Tone receiver reports DTMF activity |
| pwr_dn | input | 1 | Power-down, high forces outputs high |
| fsk_mode | output | 1 | 1 when FSK selected, 0 for DTMF |
| dout | output | 1 | Forwarded serial data |
| dv_n | output | 1 | Active-low data valid |

## Verification
The bench keeps the default seizure and mark thresholds of 16 and 8, so the preamble and mark counts are exercised at their real lengths. It does include off-by-one runs of 15 alternating bits and 7 mark bits. It shortens IDLE_CYC to 400 cycles and strobes a bit every 8 cycles, so a whole frame (80 cycles) fits well inside one idle window. This brings both the timeout and its restart by a start bit within a few hundred cycles.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,
        S_SEIZE = 2'd1,
        S_MARK  = 2'd2,
        S_DATA  = 2'd3
    } fsd_state_t;
endpackage

// File: rtl/fsd_alt_detect.sv
// Tracks the length of the current run of alternating bits.
module fsd_alt_detect #(
    parameter int SEIZE_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic bit_in,
    output logic seize_hit,
    output logic rep_one,
    output logic rep_zero
);
    localparam int RW = $clog2(SEIZE_MIN + 1);

    logic [RW-1:0] run_q;
    logic          prev_q;
    logic          ok_q;
    logic [RW:0]   run_nx;
    logic          alt;

    assign alt    = ok_q && (bit_in != prev_q);
    assign run_nx = alt ? ({1'b0, run_q} + 1'b1) : (RW+1)'(1);

    assign seize_hit = stb && !clr && (run_nx >= (RW+1)'(SEIZE_MIN));
    assign rep_one   = stb && !clr && ok_q && prev_q && bit_in;
    assign rep_zero  = stb && !clr && ok_q && !prev_q && !bit_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= 1'b0;
            ok_q   <= 1'b0;
        end else if (clr) begin
            run_q  <= '0;
            ok_q   <= 1'b0;
        end else if (stb) begin
            prev_q <= bit_in;
            ok_q   <= 1'b1;
            if (run_nx >= (RW+1)'(SEIZE_MIN))
                run_q <= RW'(SEIZE_MIN);
            else
                run_q <= run_nx[RW-1:0];
        end
    end

    // R3: an equal pair always restarts the run at one
    p_run_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !clr && ok_q && (bit_in == prev_q)) |=> (run_q == RW'(1)));
endmodule

// File: rtl/fsd_frame_watch.sv
// Finds start bits in the forwarded stream and times the idle gap.
module fsd_frame_watch #(
    parameter int IDLE_CYC = 357955
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stb,
    input  logic bit_in,
    output logic timeout
);
    localparam int IW = $clog2(IDLE_CYC + 1);

    logic          in_frame_q;
    logic [3:0]    cnt_q;
    logic [IW-1:0] idle_q;
    logic          start_seen;

    assign start_seen = en && stb && !in_frame_q && !bit_in;
    assign timeout    = en && !start_seen && (idle_q >= IW'(IDLE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
            idle_q     <= '0;
        end else if (!en) begin
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
            idle_q     <= '0;
        end else begin
            if (start_seen) begin
                idle_q     <= '0;
                in_frame_q <= 1'b1;
                cnt_q      <= '0;
            end else begin
                if (idle_q < IW'(IDLE_CYC - 1))
                    idle_q <= idle_q + 1'b1;
                if (stb && in_frame_q) begin
                    if (cnt_q == 4'd8) begin
                        in_frame_q <= 1'b0;
                        cnt_q      <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    // R7: a start bit always restarts the idle window
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (idle_q == '0));
endmodule

// File: rtl/fsd_seizure_disc.sv
module fsd_seizure_disc #(
    parameter int SEIZE_MIN = 16,
    parameter int MARK_MIN  = 8,
    parameter int IDLE_CYC  = 357955
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_in,
    input  logic dtmf_act,
    input  logic pwr_dn,
    output logic fsk_mode,
    output logic dout,
    output logic dv_n
);
    import fsd_pkg::*;

    localparam int MW = $clog2(MARK_MIN + 2);

    fsd_state_t    state_q, state_nx;
    logic [MW-1:0] ones_q;
    logic          dout_q;
    logic          alt_clr, seize_hit, rep_one, rep_zero, timeout;

    assign alt_clr = dtmf_act || pwr_dn || (state_q == S_MARK) || (state_q == S_DATA);

    fsd_alt_detect #(.SEIZE_MIN(SEIZE_MIN)) u_alt (
        .clk(clk), .rst_n(rst_n), .clr(alt_clr), .stb(bit_stb), .bit_in(bit_in),
        .seize_hit(seize_hit), .rep_one(rep_one), .rep_zero(rep_zero)
    );

    fsd_frame_watch #(.IDLE_CYC(IDLE_CYC)) u_frm (
        .clk(clk), .rst_n(rst_n), .en(state_q == S_DATA), .stb(bit_stb),
        .bit_in(bit_in), .timeout(timeout)
    );

    // next-state decision
    always_comb begin
        state_nx = state_q;
        if (pwr_dn) begin
            state_nx = S_HUNT;
        end else begin
            unique case (state_q)
                S_HUNT:  if (seize_hit) state_nx = S_SEIZE;
                S_SEIZE: begin
                    if (rep_one)
                        state_nx = (MARK_MIN <= 2) ? S_DATA : S_MARK;
                    else if (rep_zero)
                        state_nx = S_HUNT;
                end
                S_MARK: begin
                    if (bit_stb) begin
                        if (!bit_in)
                            state_nx = S_HUNT;
                        else if (({1'b0, ones_q} + 1'b1) >= (MW+1)'(MARK_MIN))
                            state_nx = S_DATA;
                    end
                end
                S_DATA:  if (timeout) state_nx = S_HUNT;
                default: state_nx = S_HUNT;
            endcase
        end
    end

    // state register and mark counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HUNT;
            ones_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == S_SEIZE && rep_one)
                ones_q <= MW'(2);
            else if (state_q == S_MARK && bit_stb && bit_in && ones_q < MW'(MARK_MIN))
                ones_q <= ones_q + 1'b1;
            else if (state_q != S_MARK)
                ones_q <= '0;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout_q <= 1'b1;
        else if (state_nx != S_DATA)
            dout_q <= 1'b1;
        else if (state_q == S_DATA && bit_stb)
            dout_q <= bit_in;
    end

    assign fsk_mode = (state_q != S_HUNT);
    assign dv_n     = pwr_dn || (state_q != S_DATA);
    assign dout     = pwr_dn ? 1'b1 : dout_q;

    // R4: data-valid only opens straight out of the mark run
    p_dv_after_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_n) |-> ($past(state_q) == S_MARK));
    // R2 / R8: FSK is chosen only on a strobed bit with no DTMF activity
    p_mode_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsk_mode) |-> ($past(bit_stb) && !$past(dtmf_act)));
    // R9: power-down drops the mode on the next cycle
    p_pdn_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!fsk_mode && dv_n));
    // R5: no bit leaves the block while data-valid is high
    p_quiet_dout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dv_n |-> dout);
endmodule

// File: tb/sim_fsd_seizure_disc.sv
module sim_fsd_seizure_disc;
    localparam int CLK_PER   = 10;
    localparam int SEIZE_MIN = 16;
    localparam int MARK_MIN  = 8;
    localparam int IDLE_CYC  = 400;

    logic clk = 1'b0;
    logic rst_n, bit_stb, bit_in, dtmf_act, pwr_dn;
    logic fsk_mode, dout, dv_n;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    fsd_seizure_disc #(.SEIZE_MIN(SEIZE_MIN), .MARK_MIN(MARK_MIN), .IDLE_CYC(IDLE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
        .dtmf_act(dtmf_act), .pwr_dn(pwr_dn),
        .fsk_mode(fsk_mode), .dout(dout), .dv_n(dv_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; bit_stb = 1'b0; bit_in = 1'b1; dtmf_act = 1'b0; pwr_dn = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one bit per 8 clocks, sampled at a negedge after its strobe
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_stb = 1'b1; bit_in = b;
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_alt(input int n);
        for (int i = 0; i < n; i++) send_bit(1'(i % 2));
    endtask

    task automatic enter_data();
        reset_dut();
        send_alt(SEIZE_MIN);
        for (int i = 0; i < MARK_MIN - 1; i++) send_bit(1'b1);
    endtask

    task automatic send_frame(input logic [7:0] d, input string req);
        send_bit(1'b0);
        check({req, " start"}, dout, 1'b0);
        for (int i = 0; i < 8; i++) begin
            send_bit(d[i]);
            check({req, " data"}, dout, d[i]);
        end
        send_bit(1'b1);
        check({req, " stop"}, dout, 1'b1);
    endtask

    task automatic t_reset();
        reset_dut();
        check("R1 mode", fsk_mode, 1'b0);
        check("R1 dout", dout, 1'b1);
        check("R1 dv_n", dv_n, 1'b1);
    endtask

    task automatic t_main();
        reset_dut();
        send_alt(SEIZE_MIN - 1);
        check("R2 below threshold", fsk_mode, 1'b0);
        send_bit(1'b1);
        check("R2 seize", fsk_mode, 1'b1);
        check("R2 dv_n", dv_n, 1'b1);
        for (int i = 0; i < MARK_MIN - 2; i++) begin
            send_bit(1'b1);
            check("R4 mark pending", dv_n, 1'b1);
            check("R5 mark hidden", dout, 1'b1);
        end
        send_bit(1'b1);
        check("R4 mark done", dv_n, 1'b0);
        check("R6 idle mark", dout, 1'b1);
        send_frame(8'hA5, "R6 A5");
        send_frame(8'h3C, "R6 3C");
        repeat (IDLE_CYC - 200) @(negedge clk);
        check("R7 before timeout", dv_n, 1'b0);
        repeat (260) @(negedge clk);
        check("R7 timeout dv_n", dv_n, 1'b1);
        check("R7 timeout mode", fsk_mode, 1'b0);
        check("R7 timeout dout", dout, 1'b1);
    endtask

    task automatic t_start_restart();
        enter_data();
        check("R7 in data", dv_n, 1'b0);
        repeat (300) @(negedge clk);
        send_frame(8'h01, "R7 frame");
        repeat (250) @(negedge clk);
        check("R7 start bit restarts window", dv_n, 1'b0);
        repeat (150) @(negedge clk);
        check("R7 later timeout", dv_n, 1'b1);
    endtask

    task automatic t_break();
        reset_dut();
        send_alt(10);
        send_bit(1'b1);
        send_alt(SEIZE_MIN - 2);
        check("R3 restarted count", fsk_mode, 1'b0);
        send_bit(1'b0);
        check("R3 full run again", fsk_mode, 1'b1);
    endtask

    task automatic t_mark_abort();
        reset_dut();
        send_alt(SEIZE_MIN);
        send_bit(1'b1);
        send_bit(1'b1);
        check("R4 in mark", fsk_mode, 1'b1);
        send_bit(1'b0);
        check("R4 mark abort", fsk_mode, 1'b0);
        check("R4 mark abort dv_n", dv_n, 1'b1);
    endtask

    task automatic t_seize_break();
        reset_dut();
        send_alt(SEIZE_MIN);
        send_bit(1'b0);
        check("R10 still seized", fsk_mode, 1'b1);
        send_bit(1'b0);
        check("R10 double space", fsk_mode, 1'b0);
    endtask

    task automatic t_dtmf();
        reset_dut();
        dtmf_act = 1'b1;
        send_alt(20);
        check("R8 held in search", fsk_mode, 1'b0);
        dtmf_act = 1'b0;
        send_alt(SEIZE_MIN - 1);
        check("R8 count cleared", fsk_mode, 1'b0);
        send_bit(1'b1);
        check("R8 seize after release", fsk_mode, 1'b1);
    endtask

    task automatic t_pdn();
        enter_data();
        send_bit(1'b0);
        check("R9 data low", dout, 1'b0);
        @(negedge clk);
        pwr_dn = 1'b1;
        #1;
        check("R9 dout forced", dout, 1'b1);
        check("R9 dv_n forced", dv_n, 1'b1);
        @(negedge clk);
        check("R9 mode dropped", fsk_mode, 1'b0);
        pwr_dn = 1'b0;
        @(negedge clk);
        check("R9 stays in search", dv_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_main();
        t_start_restart();
        t_break();
        t_mark_abort();
        t_seize_break();
        t_dtmf();
        t_pdn();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule